// File: doc/BRIEF.md
# Serial Register Scan Readout

This block gives a non-destructive way to read back any 12-bit configuration word or any of the three timing counters of a video sync generator through one output pin. The pin normally carries the odd/even field flag. The address-load logic presents a six-bit address. When that address falls in the scan window, the block raises a freeze signal that stops the timing core. On each rising clock edge after the load strobe returns high, the block presents one bit of the selected value on the pin.

The value is copied into a private shift register when the strobe rises, so the stored configuration is never changed by the readout. Bits leave least significant first. Once all twelve bits have been shown, further edges keep presenting the top bit. Raising the strobe again after a low phase takes a fresh copy. Loading any address outside the window drops the freeze, and the core carries on from the point where it stopped.

Top module: `scan_readout`

## Requirements
- R1: `core_freeze` is high exactly when `addr` lies in 32..53, and low for every other address, including 31 and 54.
- R2: Addresses 32..50 select configuration word `addr-32`, where word k sits at `reg_view[12k+11:12k]`. Addresses 51, 52 and 53 select counter slices 0, 1 and 2 of `cnt_view`, where slice j sits at `cnt_view[12j+11:12j]`.
- R3: Capture happens at a clock edge where `load` is high, `load` was low at the previous edge, and `addr` is a scan address. Right after that edge, `oe_pin` shows bit 0 of the selected value.
- R4: At each later edge where `load` stays high, the pin advances by one bit, LSB first. After i such edges it shows bit i.
- R5: After bit 11 has been reached, further edges with `load` high keep showing bit 11.
- R6: While `load` is low at an edge, the pin holds its current bit.
- R7: When `load` rises again after a low phase on a scan address, the current value is recaptured and shifting restarts at bit 0.
- R8: If the source word changes after capture, the bits being shifted out are not affected. The new content only appears after the next recapture.
- R9: Outside scan mode, `oe_pin` equals `odd_even`.
- R10: While `rst_n` is low, the shift register is cleared. On a scan address the pin reads 0; on any other address the pin follows `odd_even`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 6 | Current address from the load interface |
| load | input | 1 | Load strobe level, synchronous to clk |
| reg_view | input | 228 | Parallel view of the 19 configuration words |
| cnt_view | input | 36 | Parallel view of the three counters |
| odd_even | input | 1 | Field flag from the timing core |
| core_freeze | output | 1 | Stops the timing core while high |
| oe_pin | output | 1 | Shared pin: field flag, or scan data |

## Verification
`core_freeze` and the pass-through of `odd_even` are combinational, so they are checked in the same cycle the address or flag changes. The serial pin passes through one register. The driver raises `load` after one edge with it low. At each following edge it pushes the bit that a reference model predicts, and the monitor compares that bit at the next falling edge. This means the captured bit 0 is expected half a cycle after the capture edge, and each later bit half a cycle after its own shift edge. Hold and recapture phases are scheduled step by step, so the prediction always matches the exact edge at which `load` was sampled.

// File: rtl/scan_readout.sv
module scan_readout #(
  parameter int W         = 12,
  parameter int NREG      = 19,
  parameter int NCNT      = 3,
  parameter int AW        = 6,
  parameter int SCAN_BASE = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       addr,
  input  logic                load,
  input  logic [NREG*W-1:0]   reg_view,
  input  logic [NCNT*W-1:0]   cnt_view,
  input  logic                odd_even,
  output logic                core_freeze,
  output logic                oe_pin
);
  localparam int NSRC      = NREG + NCNT;
  localparam int SCAN_LAST = SCAN_BASE + NSRC - 1;

  logic [NSRC*W-1:0] src_all;
  logic [AW-1:0]     offs;
  logic [W-1:0]      sel, sr;
  logic              in_scan, load_q;

  assign src_all = {cnt_view, reg_view};
  assign offs    = addr - AW'(SCAN_BASE);
  assign in_scan = (addr >= AW'(SCAN_BASE)) && (addr <= AW'(SCAN_LAST));

  always_comb begin
    sel = '0;
    for (int k = 0; k < NSRC; k++)
      if (offs == AW'(k)) sel = src_all[k*W +: W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr     <= '0;
      load_q <= 1'b0;
    end else begin
      load_q <= load;
      if (in_scan && load) begin
        if (!load_q) sr <= sel;
        else         sr <= {sr[W-1], sr[W-1:1]};
      end
    end
  end

  assign core_freeze = in_scan;
  assign oe_pin      = in_scan ? sr[0] : odd_even;
endmodule

// File: rtl/scan_readout_chk.sv
module scan_readout_chk #(
  parameter int W         = 12,
  parameter int NREG      = 19,
  parameter int NCNT      = 3,
  parameter int AW        = 6,
  parameter int SCAN_BASE = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [AW-1:0]     addr,
  input logic              load,
  input logic [NREG*W-1:0] reg_view,
  input logic [NCNT*W-1:0] cnt_view,
  input logic              odd_even,
  input logic              core_freeze,
  input logic              oe_pin
);
  localparam int NSRC = NREG + NCNT;
  logic       ld_q, exp0;
  logic [3:0] nshift;
  logic [AW-1:0] offs;

  assign offs = addr - AW'(SCAN_BASE);

  always_comb begin
    exp0 = 1'b0;
    for (int k = 0; k < NREG; k++)
      if (offs == AW'(k)) exp0 = reg_view[k*W];
    for (int j = 0; j < NCNT; j++)
      if (offs == AW'(NREG + j)) exp0 = cnt_view[j*W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_q   <= 1'b0;
      nshift <= '0;
    end else begin
      ld_q <= load;
      if (core_freeze && load) begin
        if (!ld_q) nshift <= '0;
        else if (nshift < 4'(W-1)) nshift <= nshift + 4'd1;
      end
    end
  end

  a_r3_capture_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    (core_freeze && load && !ld_q) |=> (!core_freeze || !$stable(addr) || oe_pin == $past(exp0)));

  a_r5_msb_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (core_freeze && load && ld_q && nshift == 4'(W-1)) |=> (!core_freeze || !$stable(addr) || $stable(oe_pin)));

  a_r6_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    (core_freeze && $past(core_freeze) && $past(!load) && $past(rst_n) && $stable(addr)) |-> $stable(oe_pin));

  a_r9_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    !core_freeze |-> (oe_pin == odd_even));
endmodule

bind scan_readout scan_readout_chk #(
  .W(W), .NREG(NREG), .NCNT(NCNT), .AW(AW), .SCAN_BASE(SCAN_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .load(load), .reg_view(reg_view),
  .cnt_view(cnt_view), .odd_even(odd_even), .core_freeze(core_freeze), .oe_pin(oe_pin)
);

// File: tb/test_scan_readout.sv
module test_scan_readout;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, load = 1'b0, odd_even = 1'b0;
  logic [5:0] addr = '0;
  logic [11:0] rw [19];
  logic [11:0] cw [3];
  logic [228-1:0] reg_view;
  logic [36-1:0] cnt_view;
  logic core_freeze, oe_pin;
  int nchk = 0, nfail = 0;
  bit done = 0;

  typedef struct { logic exp; string tag; } item_t;
  item_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int k = 0; k < 19; k++) reg_view[k*12 +: 12] = rw[k];
    for (int j = 0; j < 3; j++)  cnt_view[j*12 +: 12] = cw[j];
  end

  scan_readout i_scan_readout (
    .clk(clk), .rst_n(rst_n), .addr(addr), .load(load), .reg_view(reg_view),
    .cnt_view(cnt_view), .odd_even(odd_even), .core_freeze(core_freeze), .oe_pin(oe_pin)
  );

  always @(negedge clk) begin
    item_t it;
    if (q.size() > 0) begin
      it = q.pop_front();
      nchk++;
      if (oe_pin !== it.exp) begin
        nfail++;
        $display("FAIL %s: oe_pin=%0b expected %0b", it.tag, oe_pin, it.exp);
      end
    end
  end

  task automatic check(input logic act, input logic exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] src_of(input int a);
    return (a < 51) ? rw[a-32] : cw[a-51];
  endfunction

  task automatic scan_run(input int a, input int nsteps, input logic [31:0] lowmask, input int chg_step);
    logic [11:0] snap = '0;
    int pos = 0;
    logic prev, lvl;
    bit chg = 0;
    string tg;
    @(posedge clk); #1; addr = 6'(a); load = 1'b0;
    @(posedge clk); #1;
    prev = 1'b0;
    for (int s = 0; s < nsteps; s++) begin
      if (s == chg_step) begin rw[a-32] = rw[a-32] ^ 12'hFFF; chg = 1; end
      lvl = !lowmask[s];
      load = lvl;
      @(posedge clk); #1;
      if (lvl && !prev) begin
        snap = src_of(a); pos = 0; chg = 0;
        tg = (s == 0) ? "R3" : "R7";
      end else if (lvl) begin
        tg = (pos == 11) ? "R5" : (chg ? "R8" : (a >= 51 ? "R2" : "R4"));
        if (pos < 11) pos++;
      end else tg = "R6";
      prev = lvl;
      q.push_back('{snap[pos], tg});
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*50000);
    nfail++; nchk++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    for (int k = 0; k < 19; k++) rw[k] = 12'hA53 ^ 12'(k * 12'h127);
    cw[0] = 12'h8C1; cw[1] = 12'h3E6; cw[2] = 12'hF09;
    addr = 6'd32; odd_even = 1'b1;
    repeat (2) @(posedge clk);
    #1; check(oe_pin, 1'b0, "R10 scan pin in reset");
    addr = 6'd5; #1; check(oe_pin, 1'b1, "R10 passthru in reset");
    @(negedge clk); rst_n = 1'b1;

    addr = 6'd31; #1; check(core_freeze, 1'b0, "R1 addr31");
    addr = 6'd32; #1; check(core_freeze, 1'b1, "R1 addr32");
    addr = 6'd53; #1; check(core_freeze, 1'b1, "R1 addr53");
    addr = 6'd54; #1; check(core_freeze, 1'b0, "R1 addr54");
    addr = 6'd22; #1; check(core_freeze, 1'b0, "R1 addr22");
    odd_even = 1'b0; #1; check(oe_pin, 1'b0, "R9 flag low");
    odd_even = 1'b1; #1; check(oe_pin, 1'b1, "R9 flag high");

    scan_run(32, 15, 32'h0, -1);
    scan_run(50, 12, 32'h0000_0038, -1);
    scan_run(51, 13, 32'h0, -1);
    scan_run(52, 13, 32'h0, -1);
    scan_run(53, 13, 32'h0, -1);
    scan_run(40, 16, 32'h0000_1000, 4);

    @(posedge clk); #1; addr = 6'd3; odd_even = 1'b0;
    #1; check(core_freeze, 1'b0, "R1 resume");
    check(oe_pin, 1'b0, "R9 after scan");
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule